// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands, either both single precision or both double precision, and folds the outcome into a floating-point status word as a 2-bit condition code. The caller presents the operands, a precision select, a field select that picks one of four condition slots in the status word, and the current status value. One cycle later the block returns the updated status word. When the operands are unordered it also raises a one-cycle trap request.

The condition code is 0 for equal, 1 for first-less-than-second, 2 for first-greater and 3 for unordered. An unordered compare is handled according to an enable bit held inside the incoming status word. If the bit is set, the block requests a trap. If it is clear, the block records the event in a sticky flag in the status word and does not trap. Every status bit outside the selected slot and that flag passes through unchanged.

Top module: `fpcc_unit`

## Requirements
- R1: For ordered operands the selected field receives 0 when first equals second, 1 when first is less and 2 when first is greater.
- R2: When either operand is a NaN (all-ones exponent with a nonzero fraction), the selected field receives 3. This covers quiet and signalling NaNs alike.
- R3: The selected field is cleared before the new code is written, so a preset value never survives. All status bits other than that field and the accrued-invalid bit (bit 9) equal the incoming status.
- R4: On an unordered compare with the invalid-trap-enable bit (status bit 27) set, `trap_req` pulses together with the result, the field holds 3, and bit 9 is passed through unchanged.
- R5: On an unordered compare with bit 27 clear, bit 9 of the result is set, the field holds 3, and `trap_req` stays low.
- R6: Field select 0 addresses status bits [11:10]. Selects 1, 2 and 3 address bits [33:32], [35:34] and [37:36], which are 22, 24 and 26 places above field 0.
- R7: With `is_double` low, only bits [31:0] of each operand are compared, as single precision, and bits [63:32] are ignored. With `is_double` high, all 64 bits are compared as double precision.
- R8: Positive zero and negative zero compare equal in both precisions.
- R9: Infinities are ordered by sign like finite values and are never unordered. An infinity compares greater than the largest finite value of the same sign.
- R10: `out_valid` rises exactly one cycle after each cycle with `in_valid` high and is low otherwise. `trap_req` is high only while `out_valid` is high.
- R11: When both operands are negative, the one of larger magnitude is the lesser.
- R12: While reset is held, `out_valid`, `trap_req` and `stat_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands and status are taken this cycle |
| op_a | input | 64 | First operand; single precision uses bits [31:0] |
| op_b | input | 64 | Second operand; single precision uses bits [31:0] |
| is_double | input | 1 | 1 selects double precision, 0 single |
| fld_sel | input | 2 | Condition field to update (0..3) |
| stat_in | input | 64 | Current status word |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| stat_out | output | 64 | Updated status word |
| trap_req | output | 1 | Floating-point exception request on an unordered compare with trapping enabled |

## Verification
The compare is exercised with pairs that tell the three ordered outcomes apart in both precisions. The pairs include mixed signs and two negatives, where a plain magnitude compare would invert the answer. Signed zeros and infinities probe the edges of ordering. Quiet and signalling NaNs on either side are sent once with trapping enabled and once with it disabled, which separates the trap path from the sticky-flag path. Operand words whose unused upper half would read as a NaN, or whose low halves are equal while the full doubles differ, show that the precision select really picks the compared bits. Status words full of ones and with a preset field show that only the chosen slot is rewritten.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int unsigned DBL_W = 64;
    localparam int unsigned SGL_W = 32;
    localparam int unsigned MAG_W = DBL_W - 1;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UN = 2'd3
    } cc_e;

    // Precision-neutral view of one operand
    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             nan;
        logic             zero;
    } fp_key_t;

    // Field 0 sits at the base; the rest sit 20 + 2*idx above it
    function automatic int unsigned field_lsb(input int unsigned base, input int unsigned idx);
        return (idx == 0) ? base : base + 20 + 2 * idx;
    endfunction

    function automatic fp_key_t key_of_single(input logic [SGL_W-1:0] w);
        fp_key_t k;
        k.sign = w[31];
        k.mag  = {{(MAG_W-31){1'b0}}, w[30:0]};
        k.nan  = (&w[30:23]) && (|w[22:0]);
        k.zero = (w[30:0] == '0);
        return k;
    endfunction

    function automatic fp_key_t key_of_double(input logic [DBL_W-1:0] w);
        fp_key_t k;
        k.sign = w[63];
        k.mag  = w[62:0];
        k.nan  = (&w[62:52]) && (|w[51:0]);
        k.zero = (w[62:0] == '0);
        return k;
    endfunction

endpackage

// File: rtl/fpcc_unpack.sv
module fpcc_unpack
    import fpcc_pkg::*;
(
    input  logic [DBL_W-1:0] raw,
    input  logic             is_double,
    output fp_key_t          key
);
    fp_key_t k_sgl;
    fp_key_t k_dbl;

    always_comb begin
        k_sgl = key_of_single(raw[SGL_W-1:0]);
        k_dbl = key_of_double(raw);
        key   = is_double ? k_dbl : k_sgl;
    end
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
    import fpcc_pkg::*;
(
    input  fp_key_t key_a,
    input  fp_key_t key_b,
    output cc_e     code
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = key_a.mag < key_b.mag;
        mag_eq = key_a.mag == key_b.mag;
        if (key_a.nan || key_b.nan)
            code = CC_UN;
        else if (key_a.zero && key_b.zero)
            code = CC_EQ;
        else if (key_a.sign != key_b.sign)
            code = key_a.sign ? CC_LT : CC_GT;
        else if (mag_eq)
            code = CC_EQ;
        else
            code = (mag_lt ^ key_a.sign) ? CC_LT : CC_GT;
    end
endmodule

// File: rtl/fpcc_merge.sv
module fpcc_merge
    import fpcc_pkg::*;
#(
    parameter int unsigned STAT_W     = 64,
    parameter int unsigned FIELD_BASE = 10,
    parameter int unsigned NX_BIT     = 9,
    parameter int unsigned TE_BIT     = 27,
    parameter int unsigned N_FIELDS   = 4,
    localparam int unsigned SEL_W     = $clog2(N_FIELDS)
) (
    input  logic [STAT_W-1:0] stat_in,
    input  logic [SEL_W-1:0]  sel,
    input  cc_e               code,
    output logic [STAT_W-1:0] stat_next,
    output logic              trap
);
    logic [STAT_W-1:0] clr_part [N_FIELDS];
    logic [STAT_W-1:0] set_part [N_FIELDS];

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        localparam int unsigned LSB = field_lsb(FIELD_BASE, g);
        logic hit;
        assign hit         = (sel == SEL_W'(g));
        assign clr_part[g] = (STAT_W'(3) << LSB) & {STAT_W{hit}};
        assign set_part[g] = (STAT_W'(code) << LSB) & {STAT_W{hit}};
    end

    logic [STAT_W-1:0] clr_mask;
    logic [STAT_W-1:0] set_bits;
    logic              unordered;

    always_comb begin
        clr_mask = '0;
        set_bits = '0;
        for (int i = 0; i < N_FIELDS; i++) begin
            clr_mask = clr_mask | clr_part[i];
            set_bits = set_bits | set_part[i];
        end
        unordered = (code == CC_UN);
        stat_next = (stat_in & ~clr_mask) | set_bits;
        trap      = 1'b0;
        if (unordered) begin
            if (stat_in[TE_BIT])
                trap = 1'b1;
            else
                stat_next[NX_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
    import fpcc_pkg::*;
#(
    parameter int unsigned STAT_W     = 64,
    parameter int unsigned FIELD_BASE = 10,
    parameter int unsigned NX_BIT     = 9,
    parameter int unsigned TE_BIT     = 27,
    parameter int unsigned N_FIELDS   = 4,
    localparam int unsigned SEL_W     = $clog2(N_FIELDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DBL_W-1:0]  op_a,
    input  logic [DBL_W-1:0]  op_b,
    input  logic              is_double,
    input  logic [SEL_W-1:0]  fld_sel,
    input  logic [STAT_W-1:0] stat_in,
    output logic              out_valid,
    output logic [STAT_W-1:0] stat_out,
    output logic              trap_req
);
    fp_key_t           key_a;
    fp_key_t           key_b;
    cc_e               code;
    logic [STAT_W-1:0] stat_nx;
    logic              trap_nx;

    fpcc_unpack u_unpack_a (.raw(op_a), .is_double(is_double), .key(key_a));
    fpcc_unpack u_unpack_b (.raw(op_b), .is_double(is_double), .key(key_b));

    fpcc_order u_order (.key_a(key_a), .key_b(key_b), .code(code));

    fpcc_merge #(
        .STAT_W(STAT_W), .FIELD_BASE(FIELD_BASE), .NX_BIT(NX_BIT),
        .TE_BIT(TE_BIT), .N_FIELDS(N_FIELDS)
    ) u_merge (
        .stat_in(stat_in), .sel(fld_sel), .code(code),
        .stat_next(stat_nx), .trap(trap_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            trap_req  <= 1'b0;
            stat_out  <= '0;
        end else begin
            out_valid <= in_valid;
            trap_req  <= in_valid && trap_nx;
            if (in_valid)
                stat_out <= stat_nx;
        end
    end
endmodule

// File: rtl/fpcc_unit_chk.sv
module fpcc_unit_chk
    import fpcc_pkg::*;
#(
    parameter int unsigned STAT_W     = 64,
    parameter int unsigned FIELD_BASE = 10,
    parameter int unsigned NX_BIT     = 9,
    parameter int unsigned TE_BIT     = 27,
    parameter int unsigned N_FIELDS   = 4,
    localparam int unsigned SEL_W     = $clog2(N_FIELDS)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [SEL_W-1:0]  fld_sel,
    input logic [STAT_W-1:0] stat_in,
    input logic              out_valid,
    input logic [STAT_W-1:0] stat_out,
    input logic              trap_req
);
    int unsigned       lsb_now;
    logic [STAT_W-1:0] keep_now;

    always_comb begin
        lsb_now  = field_lsb(FIELD_BASE, int'(fld_sel));
        keep_now = ~((STAT_W'(3) << lsb_now) | (STAT_W'(1) << NX_BIT));
    end

    // R10: result strobe follows each request by one cycle
    p_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R10: no result without a request
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R10: trap only alongside a result
    p_trap_with_valid_r10: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> out_valid);
    // R4: trap only when the enable bit was set in the request
    p_trap_only_enabled_r4: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(stat_in[TE_BIT]));
    // R4: trapping leaves the accrued flag as it came in
    p_trap_no_accrue_r4: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (stat_out[NX_BIT] == $past(stat_in[NX_BIT])));
    // R2: a trap means the selected field reads unordered
    p_field_code_un_r2: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (((stat_out >> $past(lsb_now)) & STAT_W'(3)) == STAT_W'(3)));
    // R3: bits outside the field and flag pass through
    p_preserve_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((stat_out & $past(keep_now)) == ($past(stat_in) & $past(keep_now))));
endmodule

bind fpcc_unit fpcc_unit_chk #(
    .STAT_W(STAT_W), .FIELD_BASE(FIELD_BASE), .NX_BIT(NX_BIT),
    .TE_BIT(TE_BIT), .N_FIELDS(N_FIELDS)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fld_sel(fld_sel),
    .stat_in(stat_in), .out_valid(out_valid), .stat_out(stat_out),
    .trap_req(trap_req)
);

// File: tb/fpcc_unit_bench.sv
module fpcc_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        is_double = 1'b0;
    logic [1:0]  fld_sel = '0;
    logic [63:0] stat_in = '0;
    logic        out_valid;
    logic [63:0] stat_out;
    logic        trap_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] q_stat [$];
    logic        q_trap [$];
    string       q_tag  [$];

    always #2.5 clk = ~clk;

    fpcc_unit u_fpcc_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .is_double(is_double), .fld_sel(fld_sel), .stat_in(stat_in),
        .out_valid(out_valid), .stat_out(stat_out), .trap_req(trap_req)
    );

    function automatic int pos_of(input logic [1:0] s);
        case (s)
            2'd0:    return 10;
            2'd1:    return 32;
            2'd2:    return 34;
            default: return 36;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one request per call, expected result pushed to the scoreboard
    task automatic send(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                        input logic [1:0] sel, input logic [63:0] st,
                        input logic [1:0] code, input string tag);
        logic [63:0] e;
        bit          t;
        int          p;
        p = pos_of(sel);
        e = (st & ~(64'h3 << p)) | ({62'd0, code} << p);
        t = 1'b0;
        if (code == 2'd3) begin
            if (st[27]) t = 1'b1;
            else        e[9] = 1'b1;
        end
        q_stat.push_back(e);
        q_trap.push_back(t);
        q_tag.push_back(tag);
        op_a = a; op_b = b; is_double = dbl; fld_sel = sel; stat_in = st;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare results as they appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_stat.size() == 0) begin
                check(1'b0, "R10 unexpected out_valid", 64'd1, 64'd0);
            end else begin
                logic [63:0] es;
                logic        et;
                string       tg;
                es = q_stat.pop_front();
                et = q_trap.pop_front();
                tg = q_tag.pop_front();
                check(stat_out == es, {tg, " stat"}, stat_out, es);
                check(trap_req == et, {tg, " trap"}, {63'd0, trap_req}, {63'd0, et});
            end
        end else if (!rst) begin
            checks++;
            if (trap_req) begin
                errors++;
                $display("FAIL R10: trap_req without out_valid actual 1 expected 0");
            end
        end
    end

    localparam logic [63:0] S_ZERO = 64'h0;
    localparam logic [63:0] S_ONES = 64'hFFFF_FFFF_F7FF_FFFF; // trap enable clear
    localparam logic [63:0] S_NXQ  = 64'h1234_5678_0000_0000; // trap enable clear, flag clear
    localparam logic [63:0] S_TE   = 64'h0000_00FF_0800_0C00; // trap enable set, field0 preset

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R12 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check(trap_req == 1'b0, "R12 trap_req in reset", {63'd0, trap_req}, 64'd0);
        check(stat_out == 64'd0, "R12 stat_out in reset", stat_out, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        send(64'h3F800000, 64'h3F800000, 0, 2'd0, S_ONES, 2'd0, "R1 single equal");
        send(64'h3F800000, 64'h40000000, 0, 2'd1, S_ZERO, 2'd1, "R1 R6 single less field1");
        send(64'h40000000, 64'h3F800000, 0, 2'd2, S_ONES, 2'd2, "R1 R6 single greater field2");
        send(64'h4000000000000000, 64'hC008000000000000, 1, 2'd3, S_ZERO, 2'd2, "R6 double greater field3");
        send(64'hC008000000000000, 64'h3FF0000000000000, 1, 2'd0, S_ZERO, 2'd1, "R1 double mixed sign less");
        send(64'hC0000000, 64'hBF800000, 0, 2'd0, S_ZERO, 2'd1, "R11 single two negatives");
        send(64'hBFF0000000000000, 64'hC008000000000000, 1, 2'd1, S_ZERO, 2'd2, "R11 double two negatives");
        send(64'hC008000000000000, 64'hC008000000000000, 1, 2'd3, S_ONES, 2'd0, "R1 double equal negatives");
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R10 idle gap", {63'd0, out_valid}, 64'd0);

        send(64'h00000000, 64'h80000000, 0, 2'd2, S_ONES, 2'd0, "R8 single signed zeros");
        send(64'h8000000000000000, 64'h0, 1, 2'd1, S_ZERO, 2'd0, "R8 double signed zeros");
        send(64'h7F800000, 64'h40000000, 0, 2'd0, S_ZERO, 2'd2, "R9 single inf greater");
        send(64'hFFF0000000000000, 64'h4000000000000000, 1, 2'd0, S_ZERO, 2'd1, "R9 double minus inf less");
        send(64'h7F800000, 64'h7F800000, 0, 2'd3, S_ZERO, 2'd0, "R9 inf equal inf");
        send(64'h7FEFFFFFFFFFFFFF, 64'h7FF0000000000000, 1, 2'd2, S_ZERO, 2'd1, "R9 max finite below inf");
        send(64'h7FC00000, 64'h3F800000, 0, 2'd0, S_NXQ, 2'd3, "R2 R5 quiet nan no trap");
        send(64'h3FF0000000000000, 64'h7FF8000000000000, 1, 2'd1, S_TE, 2'd3, "R2 R4 double nan trap");
        send(64'h7F800001, 64'h7F800000, 0, 2'd2, S_TE, 2'd3, "R2 R4 signalling nan trap");
        send(64'hFFFFFFFF_3F800000, 64'h00000000_40000000, 0, 2'd3, S_ZERO, 2'd1, "R7 single ignores upper");
        send(64'h4000000000000000, 64'h3FF0000000000000, 1, 2'd0, S_ZERO, 2'd2, "R7 double uses upper");
        send(64'h3FF00000_7FC00000, 64'h3FF00000_3F800000, 0, 2'd3, S_NXQ, 2'd3, "R7 R5 single nan in low half");
        send(64'h3F800000, 64'h3F800000, 0, 2'd0, S_TE, 2'd0, "R3 preset field cleared no trap");
        send(64'hBF800000, 64'h3F800000, 0, 2'd0, S_TE, 2'd1, "R3 preset field rewritten");

        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R10 idle after burst", {63'd0, out_valid}, 64'd0);
        check(q_stat.size() == 0, "R10 all results seen", 64'(q_stat.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10: watchdog expired actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule